// File: doc/BRIEF.md
# Token Injection Sequencer

This block turns the contents of a memory region into a stream of 16-bit flits. In replay mode each stored token takes two neighbouring cells: the lower cell holds the token's first flit and the higher cell its second. The sequencer reads them in rising address order and sends them out unchanged. In walk mode it visits a run of cells and sends one two-flit result token per cell. The first flit of each result token is a caller-supplied template word and the second is the cell's contents.

Replay mode serves two purposes. A start command with a base address and an entry count injects a stored token list. When reset is released, the block replays a fixed region with no command at all, which loads and seeds the rest of the machine. Reads go through a plain synchronous read port with one cycle of latency. The region is raw memory, so a read never waits on cell state. The flit output uses a valid/ready handshake.

Top module: `tok_inject_seq`

## Requirements
- R1: In replay mode (cmd_mode = 0) each token is read from cells base+2k (first flit) and base+2k+1 (second flit), and tokens leave in rising address order.
- R2: The replay entry count is the low 8 bits of cmd_len, and the upper bits are ignored. It counts two-cell tokens, so a count of n emits 2n flits and performs 2n reads. The largest count, 255, is accepted.
- R3: While reset is low, busy is high and cmd_ready and out_valid are low. After release, the block replays BOOT_COUNT tokens starting at BOOT_BASE without any command.
- R4: In walk mode (cmd_mode = 1), cmd_len is a 16-bit cell count. For each cell base+k the block emits the template word followed by that cell's data, so lengths above 255 are honoured.
- R5: busy is high and cmd_ready is low from the accepting edge (or from reset release) until the edge that accepts the final flit. While idle, busy is low, cmd_ready is high and out_valid is low.
- R6: While out_valid is high and out_ready is low, out_flit holds steady. Each cell of a run is read exactly once: 2n reads in replay mode, n reads in walk mode.
- R7: A start command with a count or length of zero emits no flit, performs no read and leaves busy low.
- R8: A template flit is valid from the edge that accepts the command or the preceding flit. A flit read from memory is valid two edges after that edge.
- R9: The read address wraps modulo 2^16, so a run that starts near the top of the address space continues from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; its release starts the boot replay |
| cmd_valid | input | 1 | A start command is offered |
| cmd_ready | output | 1 | A start command is taken on this edge if offered |
| cmd_mode | input | 1 | 0 = replay stored tokens, 1 = walk cells with template |
| cmd_base | input | 16 | First cell address of the run |
| cmd_len | input | 16 | Replay: token count in bits 7:0; walk: cell count |
| cmd_tmpl | input | 16 | Template word used as the first flit in walk mode |
| busy | output | 1 | A run (or the pending boot replay) is in progress |
| mem_rd_en | output | 1 | Read strobe to the cell memory |
| mem_rd_addr | output | 16 | Cell address being read |
| mem_rd_data | input | 16 | Read data, valid the cycle after the strobe |
| out_valid | output | 1 | out_flit holds a flit |
| out_ready | input | 1 | Downstream takes the flit on this edge |
| out_flit | output | 16 | Flit being offered |

## Verification
Every result has a fixed arrival time relative to the edge that triggers it. A template flit is offered from the accepting edge itself. A flit that comes from memory is offered two edges later, after the read strobe and the capture cycle. busy falls on the edge that takes the last flit. The bench keeps its expectation queue keyed to those edges. It samples on the falling clock and counts the rising edges since the triggering handshake, so the latency of each flit is checked along with its value. The busy and cmd_ready levels are compared with the queue occupancy on every clock.

// File: rtl/seq_inject_pkg.sv
// Shared types for the token injection sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package seq_inject_pkg;

    // Engine states: waiting, issuing a read, capturing read data, offering a flit.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_READ    = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_SEND    = 2'd3
    } sq_state_e;

    // Run flavour selected by a start command.
    typedef enum logic {
        MODE_EXEC = 1'b0,
        MODE_ITER = 1'b1
    } sq_mode_e;

endpackage

// File: rtl/sq_start_sel.sv
// Start selector: chooses between the pending boot replay and an external
// start command, and normalises the run length into a count of tokens.
// Assumes: CNT_W <= LEN_W; the boot request wins over a command; a start
// whose normalised length is zero is consumed but does not start a run.
module sq_start_sel
    import seq_inject_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned LEN_W      = 16,
    parameter logic [ADDR_W-1:0] BOOT_BASE = '0,
    parameter int unsigned BOOT_COUNT = 16
) (
    input  logic              idle,
    input  logic              boot_pend,
    input  logic              cmd_valid,
    input  logic              cmd_mode,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [DATA_W-1:0] cmd_tmpl,
    output logic              cmd_ready,
    output logic              take,
    output logic              go,
    output sq_mode_e          st_mode,
    output logic [ADDR_W-1:0] st_base,
    output logic [LEN_W-1:0]  st_units,
    output logic [DATA_W-1:0] st_tmpl
);

    localparam logic [LEN_W-1:0] BOOT_UNITS = LEN_W'(BOOT_COUNT);

    logic [LEN_W-1:0] exec_units;

    // Replay counts only use the low CNT_W bits of the length field.
    generate
        if (CNT_W < LEN_W) begin : g_ext
            assign exec_units = {{(LEN_W-CNT_W){1'b0}}, cmd_len[CNT_W-1:0]};
        end else begin : g_full
            assign exec_units = cmd_len;
        end
    endgenerate

    // Arbitration and parameter selection for the next run.
    always_comb begin
        cmd_ready = idle && !boot_pend;
        take      = idle && (boot_pend || cmd_valid);
        if (boot_pend) begin
            st_mode  = MODE_EXEC;
            st_base  = BOOT_BASE;
            st_units = BOOT_UNITS;
            st_tmpl  = '0;
        end else begin
            st_mode  = sq_mode_e'(cmd_mode);
            st_base  = cmd_base;
            st_units = (st_mode == MODE_EXEC) ? exec_units : cmd_len;
            st_tmpl  = cmd_tmpl;
        end
        go = take && (st_units != '0);
    end

endmodule

// File: rtl/sq_addr_ctr.sv
// Shared address counter and limit comparator. The pointer steps once per
// issued read; the remaining-token count drops once per finished token.
// Assumes load, step and retire are mutually exclusive in any cycle where
// load is high; the pointer wraps modulo 2^ADDR_W.
module sq_addr_ctr #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  units,
    input  logic              step,
    input  logic              retire,
    output logic [ADDR_W-1:0] ptr,
    output logic              last
);

    logic [LEN_W-1:0] remain_q;

    // Pointer and remaining-token registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            remain_q <= '0;
        end else if (load) begin
            ptr      <= base;
            remain_q <= units;
        end else begin
            if (step)   ptr      <= ptr + 1'b1;
            if (retire) remain_q <= remain_q - 1'b1;
        end
    end

    // Limit comparator: the token in flight is the final one.
    always_comb last = (remain_q == LEN_W'(1));

endmodule

// File: rtl/sq_flit_hold.sv
// Output flit register. Loads either the captured memory word or the
// template word and holds it while the downstream side stalls.
// Assumes ld_mem and ld_tmpl are never high together.
module sq_flit_hold #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_mem,
    input  logic              ld_tmpl,
    input  logic [DATA_W-1:0] mem_data,
    input  logic [DATA_W-1:0] tmpl,
    output logic [DATA_W-1:0] flit
);

    // Hold register for the flit on offer.
    always_ff @(posedge clk) begin
        if (!rst_n)       flit <= '0;
        else if (ld_mem)  flit <= mem_data;
        else if (ld_tmpl) flit <= tmpl;
    end

endmodule

// File: rtl/tok_inject_seq.sv
// Token injection sequencer top. Replays stored two-cell tokens (replay
// mode, also started once after reset) or walks a cell range emitting
// (template, data) tokens (walk mode). One flit is in flight at a time.
// Assumes a synchronous read port with one cycle of latency and raw
// memory that never defers a read.
module tok_inject_seq
    import seq_inject_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned LEN_W      = 16,
    parameter logic [ADDR_W-1:0] BOOT_BASE = '0,
    parameter int unsigned BOOT_COUNT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_mode,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [DATA_W-1:0] cmd_tmpl,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_flit
);

    sq_state_e         state_q, state_d;
    sq_mode_e          mode_q, st_mode;
    logic              phase_q;
    logic              boot_pend_q;
    logic [DATA_W-1:0] tmpl_q, st_tmpl, tmpl_src;
    logic [ADDR_W-1:0] st_base, ptr;
    logic [LEN_W-1:0]  st_units;
    logic              idle, take, go, last, fire, tok_done;
    logic              ld_mem, ld_tmpl;

    assign idle = (state_q == ST_IDLE);

    sq_start_sel #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .LEN_W(LEN_W),
        .BOOT_BASE(BOOT_BASE), .BOOT_COUNT(BOOT_COUNT)
    ) i_sel (
        .idle(idle), .boot_pend(boot_pend_q), .cmd_valid(cmd_valid),
        .cmd_mode(cmd_mode), .cmd_base(cmd_base), .cmd_len(cmd_len),
        .cmd_tmpl(cmd_tmpl), .cmd_ready(cmd_ready), .take(take), .go(go),
        .st_mode(st_mode), .st_base(st_base), .st_units(st_units),
        .st_tmpl(st_tmpl)
    );

    sq_addr_ctr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_ctr (
        .clk(clk), .rst_n(rst_n), .load(go), .base(st_base),
        .units(st_units), .step(mem_rd_en), .retire(tok_done && !last),
        .ptr(ptr), .last(last)
    );

    sq_flit_hold #(.DATA_W(DATA_W)) i_hold (
        .clk(clk), .rst_n(rst_n), .ld_mem(ld_mem), .ld_tmpl(ld_tmpl),
        .mem_data(mem_rd_data), .tmpl(tmpl_src), .flit(out_flit)
    );

    // Port-facing strobes derived from the engine state.
    always_comb begin
        mem_rd_en   = (state_q == ST_READ);
        mem_rd_addr = ptr;
        out_valid   = (state_q == ST_SEND);
        busy        = !idle || boot_pend_q;
        fire        = out_valid && out_ready;
        tok_done    = fire && phase_q;
        ld_mem      = (state_q == ST_CAPTURE);
        tmpl_src    = go ? st_tmpl : tmpl_q;
        ld_tmpl     = (go && (st_mode == MODE_ITER)) ||
                      (tok_done && !last && (mode_q == MODE_ITER));
    end

    // Next-state decision for the single-flit engine.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (go) state_d = (st_mode == MODE_EXEC) ? ST_READ : ST_SEND;
            ST_READ:    state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = ST_SEND;
            ST_SEND: begin
                if (fire) begin
                    if (!phase_q)             state_d = ST_READ;
                    else if (last)            state_d = ST_IDLE;
                    else if (mode_q == MODE_EXEC) state_d = ST_READ;
                    else                      state_d = ST_SEND;
                end
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    // Engine registers: state, flit phase, run mode, template, boot request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            phase_q     <= 1'b0;
            mode_q      <= MODE_EXEC;
            tmpl_q      <= '0;
            boot_pend_q <= 1'b1;
        end else begin
            state_q <= state_d;
            if (take && boot_pend_q) boot_pend_q <= 1'b0;
            if (go) begin
                phase_q <= 1'b0;
                mode_q  <= st_mode;
                tmpl_q  <= st_tmpl;
            end else if (fire) begin
                phase_q <= !phase_q;
            end
        end
    end

endmodule

// File: rtl/tok_inject_seq_chk.sv
// Protocol checker for the token injection sequencer, bound to the top.
// Assumes the synchronous active-low reset of the design.
module tok_inject_seq_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_mode,
    input logic [LEN_W-1:0]  cmd_len,
    input logic              busy,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_flit
);

    logic              zero_req;
    logic              have_prev_q;
    logic [ADDR_W-1:0] prev_addr_q;

    // Whether the offered command carries an empty run.
    always_comb zero_req = cmd_mode ? (cmd_len == '0) : (cmd_len[CNT_W-1:0] == '0);

    // Remembers the previous read address within one run.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            have_prev_q <= 1'b0;
            prev_addr_q <= '0;
        end else if (mem_rd_en) begin
            have_prev_q <= 1'b1;
            prev_addr_q <= mem_rd_addr;
        end
    end

    // R6: a stalled flit stays on offer unchanged.
    p_hold_flit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_flit));

    // R5: nothing is offered or read while idle.
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid && !mem_rd_en);

    // R5: a non-empty accepted command makes the block busy and closed.
    p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && !zero_req |=> busy && !cmd_ready);

    // R7: an empty command leaves the block idle.
    p_zero_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && zero_req |=> !busy);

    // R8: read data is offered two edges after the strobe.
    p_read_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !out_valid ##1 out_valid);

    // R1: reads within one run step through consecutive addresses (R9 wrap).
    p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en && have_prev_q |-> mem_rd_addr == prev_addr_q + 1'b1);

endmodule

bind tok_inject_seq tok_inject_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mode(cmd_mode), .cmd_len(cmd_len), .busy(busy),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit)
);

// File: tb/test_tok_inject_seq.sv
// Self-checking bench with a behavioural expectation queue compared on every clock.
module test_tok_inject_seq;

    localparam logic [15:0] BOOT_BASE  = 16'h0100;
    localparam int          BOOT_COUNT = 4;

    typedef struct {
        logic [15:0] flit;
        int          gap;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_mode = 1'b0;
    logic [15:0] cmd_base = '0;
    logic [15:0] cmd_len = '0;
    logic [15:0] cmd_tmpl = '0;
    logic        busy;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [15:0] mem_rd_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_flit;

    int   checks = 0;
    int   failures = 0;
    int   cyc = 0;
    int   rd_cnt = 0;
    bit   bp_on = 1'b0;
    bit   finished = 1'b0;
    exp_t q[$];

    always #4 clk = !clk;

    tok_inject_seq #(.BOOT_BASE(BOOT_BASE), .BOOT_COUNT(BOOT_COUNT)) i_tok_inject_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_mode(cmd_mode), .cmd_base(cmd_base), .cmd_len(cmd_len),
        .cmd_tmpl(cmd_tmpl), .busy(busy), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit)
    );

    function automatic logic [15:0] mem_val(logic [15:0] a);
        logic [15:0] r;
        r = a * 16'h9E37;
        return r ^ 16'h5A5A ^ {a[7:0], a[15:8]};
    endfunction

    // Behavioural memory with one cycle of read latency.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_en) mem_rd_data <= mem_val(mem_rd_addr);
    end

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int push_exec(logic [15:0] base, int cnt, string tag);
        for (int i = 0; i < cnt; i++) begin
            logic [15:0] a;
            a = base + 16'(2 * i);
            q.push_back('{mem_val(a), 2, tag});
            q.push_back('{mem_val(a + 16'd1), 2, tag});
        end
        return 2 * cnt;
    endfunction

    function automatic int push_iter(logic [15:0] base, int len, logic [15:0] tmpl, string tag);
        for (int i = 0; i < len; i++) begin
            q.push_back('{tmpl, 0, tag});
            q.push_back('{mem_val(base + 16'(i)), 2, tag});
        end
        return 2 * len;
    endfunction

    // Reference model and per-clock comparison, sampled on the falling edge.
    bit          in_reset = 1'b1;
    bit          rst_checked = 1'b0;
    bit          acc_pend = 1'b0;
    bit          fire_pend = 1'b0;
    bit          wait_on = 1'b0;
    int          wait_ref = 0;
    bit          prev_stall = 1'b0;
    logic [15:0] prev_flit = '0;
    logic        acc_mode;
    logic [15:0] acc_base, acc_len, acc_tmpl;
    string       acc_tag;

    always @(negedge clk) begin
        int n;
        if (!rst_n) begin
            if (!rst_checked && cyc >= 2) begin
                rst_checked = 1'b1;
                check(busy === 1'b1, "R3", "busy in reset", busy, 1);
                check(cmd_ready === 1'b0, "R3", "cmd_ready in reset", cmd_ready, 0);
                check(out_valid === 1'b0, "R3", "out_valid in reset", out_valid, 0);
            end
            in_reset = 1'b1;
        end else begin
            if (mem_rd_en) rd_cnt++;
            if (in_reset) begin
                in_reset = 1'b0;
                n = push_exec(BOOT_BASE, BOOT_COUNT, "R3");
                wait_on = 1'b1;
                wait_ref = cyc + 1;
            end
            if (acc_pend) begin
                acc_pend = 1'b0;
                if (acc_mode) n = push_iter(acc_base, int'(acc_len), acc_tmpl, acc_tag);
                else          n = push_exec(acc_base, int'(acc_len[7:0]), acc_tag);
                if (n > 0) begin
                    wait_on = 1'b1;
                    wait_ref = cyc;
                end
            end
            if (fire_pend) begin
                fire_pend = 1'b0;
                if (q.size() != 0) begin
                    wait_on = 1'b1;
                    wait_ref = cyc;
                end
            end
            // R5: busy and cmd_ready follow the outstanding work.
            check(busy === (q.size() != 0), "R5", "busy level", busy, q.size() != 0);
            check(cmd_ready === (q.size() == 0), "R5", "cmd_ready level", cmd_ready, q.size() == 0);
            if (out_valid && q.size() == 0)
                check(1'b0, "R7", "flit offered with nothing expected", out_flit, 0);
            if (wait_on && out_valid && q.size() != 0) begin
                wait_on = 1'b0;
                check(cyc - wait_ref == q[0].gap, "R8", "flit latency in edges",
                      cyc - wait_ref, q[0].gap);
            end
            if (prev_stall)
                check(out_valid === 1'b1 && out_flit === prev_flit, "R6",
                      "stalled flit changed", out_flit, prev_flit);
            if (out_valid && out_ready && q.size() != 0) begin
                check(out_flit === q[0].flit, q[0].tag, "flit value", out_flit, q[0].flit);
                void'(q.pop_front());
                fire_pend = 1'b1;
            end
            prev_stall = out_valid && !out_ready;
            prev_flit  = out_flit;
            if (cmd_valid && cmd_ready) begin
                acc_pend = 1'b1;
                acc_mode = cmd_mode;
                acc_base = cmd_base;
                acc_len  = cmd_len;
                acc_tmpl = cmd_tmpl;
                acc_tag  = (cmd_base > 16'hFF00) ? "R9" : (cmd_mode ? "R4" : "R1");
            end
        end
    end

    // Downstream backpressure generator.
    initial begin
        logic [15:0] lfsr = 16'hACE1;
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = bp_on ? lfsr[0] : 1'b1;
        end
    end

    task automatic issue(logic mode, logic [15:0] base, logic [15:0] len, logic [15:0] tmpl);
        @(posedge clk);
        #1;
        cmd_mode = mode; cmd_base = base; cmd_len = len; cmd_tmpl = tmpl;
        cmd_valid = 1'b1;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run(logic mode, logic [15:0] base, logic [15:0] len,
                       logic [15:0] tmpl, int reads, string tag);
        int r0;
        r0 = rd_cnt;
        issue(mode, base, len, tmpl);
        wait_idle();
        check(rd_cnt - r0 == reads, tag, "read count", rd_cnt - r0, reads);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        // R3 boot replay, with a command held off until it finishes (R5).
        issue(1'b0, 16'h0020, 16'd5, 16'h0);
        wait_idle();
        check(rd_cnt == 2 * BOOT_COUNT + 10, "R3", "reads for boot plus first run",
              rd_cnt, 2 * BOOT_COUNT + 10);
        run(1'b0, 16'h0200, 16'h0A03, 16'h0, 6, "R2");     // upper count bits ignored
        run(1'b1, 16'h0300, 16'd7, 16'hC1A5, 7, "R4");     // walk mode
        run(1'b0, 16'h0400, 16'h0700, 16'h0, 0, "R7");     // replay count zero
        run(1'b1, 16'h0400, 16'd0, 16'h1234, 0, "R7");     // walk length zero
        bp_on = 1'b1;
        run(1'b0, 16'h0040, 16'd9, 16'h0, 18, "R6");       // replay under stalls
        run(1'b1, 16'h0050, 16'd20, 16'h7E01, 20, "R6");   // walk under stalls
        run(1'b0, 16'hFFFE, 16'd2, 16'h0, 4, "R9");        // wrap through zero
        run(1'b1, 16'hFFFD, 16'd5, 16'h3C3C, 5, "R9");
        run(1'b0, 16'h0000, 16'd255, 16'h0, 510, "R2");    // largest count
        bp_on = 1'b0;
        run(1'b1, 16'h0123, 16'd300, 16'hBEEF, 300, "R4"); // length above 255
        check(q.size() == 0, "R5", "leftover expected flits", q.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R5 watchdog: actual=busy-or-hung expected=idle");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule